// File: doc/BRIEF.md
# Full-Duplex Synchronous Shift Serial Port

This block is the master side of a synchronous serial link that sends and receives one byte at the same time. It drives a shift clock and a serial data output, and samples a separate serial data input. A processor-style interface writes the transmit byte, reads the received byte, and clears two sticky completion flags. Bytes move least significant bit first.

A write to the transmit buffer starts a transfer. The write arms the transmitter, which starts at the next bit-slot boundary of a free-running slot timer. The length of a bit slot is a programmable number of system clocks. No bit counter is used. A marker 1 placed above the data byte in a 9-bit transmit shifter marks the final bit. A receive shifter preloaded with a single 0 below seven 1s marks the end of reception.

The receive path takes part only when receive-enable is high at the moment of the write. When it is low, the byte goes out as usual, but the receive buffer and the receive flag are left untouched. While the port enable is low, the port is idle and writes are ignored.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, sclk_o and sdo_o are 1, tx_done_o and rx_done_o are 0, and rdata_o is 0.
- R2: Each byte is sent on sdo_o least significant bit first. sdo_o changes only together with a falling edge of sclk_o and holds its value while sclk_o is high.
- R3: sdi_i is sampled when sclk_o rises. The first bit sampled lands in bit 0 of rdata_o and the eighth in bit 7.
- R4: A transfer has exactly 8 shift clock pulses. Let N = div_i, or N = 2 when div_i < 2. Each pulse is low for floor(N/2) system clocks and high for N - floor(N/2).
- R5: The first falling edge of sclk_o comes at most N+1 system clocks after the cycle in which the write is taken.
- R6: tx_done_o is set at the end of the eighth bit slot, with sclk_o high and sdo_o back at its idle 1. It then stays set until clr_tx_i is pulsed.
- R7: If rx_en_i is 1 with the write, rdata_o takes the received byte and rx_done_o is set after the eighth sample. rx_done_o then stays set until clr_rx_i is pulsed.
- R8: If rx_en_i is 0 with the write, the byte is still sent, but rdata_o keeps its previous value and rx_done_o is not set.
- R9: A write taken while a transfer is armed or running is ignored. The byte already accepted is the one sent.
- R10: While en_i is 0, writes are ignored, sclk_o and sdo_o stay 1, and no flag is set.
- R11: Values of div_i below 2 behave as a bit slot of 2 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Port enable; low forces idle |
| rx_en_i | input | 1 | Receive enable, taken with the write |
| div_i | input | DIV_W | Bit slot length in system clocks (minimum 2) |
| wr_i | input | 1 | Transmit buffer write strobe |
| wdata_i | input | DATA_W | Byte to transmit |
| clr_tx_i | input | 1 | Clears tx_done_o |
| clr_rx_i | input | 1 | Clears rx_done_o |
| rdata_o | output | DATA_W | Receive buffer |
| tx_done_o | output | 1 | Transmit-done flag (sticky) |
| rx_done_o | output | 1 | Receive-done flag (sticky) |
| sclk_o | output | 1 | Shift clock, idles high |
| sdo_o | output | 1 | Serial data out, idles high |
| sdi_i | input | 1 | Serial data in |

## Verification
The transfer length depends on two marker bits moving through the shifters. A marker in the wrong place, or a bad shift, therefore changes the number of sclk_o pulses, and the first transfer shows it: too few or too many rising edges before tx_done_o, or a byte on sdo_o that is shifted or has a stray 1 in it. A bad receive seed either sets rx_done_o at the wrong pulse or loads rdata_o with a misaligned byte, and both are visible when tx_done_o rises. A wrong phase in the slot counter shows up as a wrong low or high width on the first sclk_o pulse, or as a start latency beyond N+1 clocks. A control state that fails to return to idle shows up at the next write, which is then dropped.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } ssp_state_e;
endpackage

// File: rtl/ssp_slot_timer.sv
module ssp_slot_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mid_o,
  output logic             end_o
);
  localparam logic [DIV_W-1:0] MIN_LEN = DIV_W'(2);
  localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

  logic [DIV_W-1:0] len, half, cnt_q;

  assign len  = (div_i < MIN_LEN) ? MIN_LEN : div_i;
  assign half = len >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (cnt_q >= len - ONE) cnt_q <= '0;
    else                        cnt_q <= cnt_q + ONE;
  end

  // low phase first, high phase second
  assign mid_o = run_i && (cnt_q == half - ONE);
  assign end_o = run_i && (cnt_q >= len - ONE);
endmodule

// File: rtl/ssp_tx_shifter.sv
module ssp_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int              SR_W     = DATA_W + 1;
  localparam logic [DATA_W-1:0] LAST_PAT = DATA_W'(1);

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= {1'b1, data_i};
    else if (shift_i) sr_q <= {1'b0, sr_q[SR_W-1:1]};
  end

  assign bit_o  = sr_q[0];
  // marker sits just above the MSB, which is at the output
  assign last_o = (sr_q[SR_W-1:1] == LAST_PAT);
endmodule

// File: rtl/ssp_rx_shifter.sv
module ssp_rx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              preload_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              full_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam logic [DATA_W-1:0] SEED = {{(DATA_W-1){1'b1}}, 1'b0};

  logic [DATA_W-1:0] sr_q, sr_nxt;

  assign sr_nxt = {sr_q[DATA_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '1;
    else if (preload_i)  sr_q <= SEED;
    else if (shift_i)    sr_q <= sr_nxt;
  end

  // seed zero at top: the coming shift completes the byte
  assign full_o = ~sr_q[DATA_W-1];

  // first bit in ends at the top; reverse so it becomes bit 0
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign byte_o[i] = sr_nxt[DATA_W-1-i];
  end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rx_en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_tx_i,
  input  logic              clr_rx_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  ssp_state_e        state_q;
  logic              sclk_q, rx_act_q, tx_done_q, rx_done_q;
  logic [DATA_W-1:0] rdata_q;

  logic mid_w, end_w, send_w, wr_ok;
  logic tx_bit, tx_last, tx_shift, tx_fin;
  logic rx_full, rx_shift, rx_fin;
  logic [DATA_W-1:0] rx_byte;

  assign send_w   = (state_q == ST_SEND);
  assign wr_ok    = en_i && wr_i && (state_q == ST_IDLE);
  assign tx_shift = send_w && end_w;
  assign tx_fin   = tx_shift && tx_last;
  assign rx_shift = send_w && mid_w && rx_act_q;
  assign rx_fin   = rx_shift && rx_full;

  ssp_slot_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .div_i  (div_i),
    .mid_o  (mid_w),
    .end_o  (end_w)
  );

  ssp_tx_shifter #(.DATA_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wr_ok),
    .data_i  (wdata_i),
    .shift_i (tx_shift),
    .bit_o   (tx_bit),
    .last_o  (tx_last)
  );

  ssp_rx_shifter #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .preload_i (wr_ok && rx_en_i),
    .shift_i   (rx_shift),
    .bit_i     (sdi_i),
    .full_o    (rx_full),
    .byte_o    (rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sclk_q   <= 1'b1;
      rx_act_q <= 1'b0;
    end else if (!en_i) begin
      state_q  <= ST_IDLE;
      sclk_q   <= 1'b1;
      rx_act_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (wr_ok) begin
          state_q  <= ST_ARMED;
          rx_act_q <= rx_en_i;
        end
        ST_ARMED: if (end_w) begin
          state_q <= ST_SEND;
          sclk_q  <= 1'b0;
        end
        ST_SEND: begin
          if (mid_w)  sclk_q   <= 1'b1;
          if (rx_fin) rx_act_q <= 1'b0;
          if (end_w) begin
            if (tx_last) state_q <= ST_IDLE;
            else         sclk_q  <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      tx_done_q <= tx_fin | (tx_done_q & ~clr_tx_i);
      rx_done_q <= rx_fin | (rx_done_q & ~clr_rx_i);
      if (rx_fin) rdata_q <= rx_byte;
    end
  end

  assign sclk_o    = sclk_q;
  assign sdo_o     = send_w ? tx_bit : 1'b1;
  assign rdata_o   = rdata_q;
  assign tx_done_o = tx_done_q;
  assign rx_done_o = rx_done_q;
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              clr_tx_i,
  input logic              clr_rx_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              tx_done_o,
  input logic              rx_done_o,
  input logic              sclk_o,
  input logic              sdo_o,
  input logic              send_i,
  input logic              rx_act_i
);
  p_idle_lines_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !send_i |-> (sclk_o && sdo_o));

  p_fall_in_send_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> send_i);

  p_tx_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_o && !clr_tx_i) |=> tx_done_o);

  p_rx_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_o && !clr_rx_i) |=> rx_done_o);

  p_tx_done_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_o) |-> ($past(send_i) && !send_i));

  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_act_i |=> $stable(rdata_o));

  p_rx_done_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_o) |-> $past(rx_act_i));

  p_off_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !send_i);
endmodule

bind sync_shift_port ssp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .clr_tx_i  (clr_tx_i),
  .clr_rx_i  (clr_rx_i),
  .rdata_o   (rdata_o),
  .tx_done_o (tx_done_o),
  .rx_done_o (rx_done_o),
  .sclk_o    (sclk_o),
  .sdo_o     (sdo_o),
  .send_i    (send_w),
  .rx_act_i  (rx_act_q)
);

// File: tb/tb_sync_shift_port.sv
`timescale 1ns/1ps
module tb_sync_shift_port;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       en = 1'b1, rx_en = 1'b0, wr = 1'b0, clr_tx = 1'b0, clr_rx = 1'b0;
  logic [7:0] div = 8'd4, wdata = '0, rdata;
  logic       tx_done, rx_done, sclk, sdo, sdi = 1'b1;

  always #2 clk = ~clk;

  sync_shift_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .rx_en_i(rx_en), .div_i(div),
    .wr_i(wr), .wdata_i(wdata), .clr_tx_i(clr_tx), .clr_rx_i(clr_rx),
    .rdata_o(rdata), .tx_done_o(tx_done), .rx_done_o(rx_done),
    .sclk_o(sclk), .sdo_o(sdo), .sdi_i(sdi)
  );

  typedef struct { logic [7:0] tx; logic [7:0] rx; bit ren; logic [7:0] old; } item_t;
  item_t q[$];

  int total = 0, bad = 0, cyc = 0, wr_cyc = 0;
  logic [7:0] slv_byte = '0;
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int n_eff();
    return (div < 2) ? 2 : int'(div);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor / slave model / scoreboard
  initial begin
    logic prev_sclk = 1'b1, prev_done = 1'b0;
    int nbits = 0, fall_c = 0, rise_c = 0;
    logic [7:0] cap = '0;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        int n, h;
        n = n_eff(); h = n / 2;
        if (sclk !== prev_sclk) begin
          if (!sclk) begin
            if (nbits == 0)
              chk((cyc - wr_cyc) >= 1 && (cyc - wr_cyc) <= n + 1, "R5 start latency", cyc - wr_cyc, n + 1);
            else begin
              chk(cyc - rise_c == n - h, "R4 high width", cyc - rise_c, n - h);
              if (nbits < 8) sdi = slv_byte[nbits];
            end
            fall_c = cyc;
          end else begin
            chk(cyc - fall_c == h, "R4 low width", cyc - fall_c, h);
            if (nbits < 8) cap[nbits] = sdo;
            nbits++;
            rise_c = cyc;
          end
        end else if (sclk && nbits > 0 && nbits <= 8 && !tx_done) begin
          if (sdo !== cap[nbits-1]) chk(0, "R2 sdo stable while sclk high", sdo, cap[nbits-1]);
        end
        if (tx_done && !prev_done) begin
          if (q.size() == 0) chk(0, "R9 unexpected completion", 1, 0);
          else begin
            item_t it;
            it = q.pop_front();
            chk(nbits == 8, "R4 pulse count", nbits, 8);
            chk(cap == it.tx, "R2 transmitted byte", cap, it.tx);
            chk(sclk && sdo, "R6 lines idle at done", {sclk, sdo}, 3);
            if (it.ren) begin
              chk(rx_done, "R7 rx_done set", rx_done, 1);
              chk(rdata == it.rx, "R3 received byte", rdata, it.rx);
            end else begin
              chk(!rx_done, "R8 rx_done stays clear", rx_done, 0);
              chk(rdata == it.old, "R8 rdata unchanged", rdata, it.old);
            end
          end
          nbits = 0;
        end
        prev_sclk = sclk;
        prev_done = tx_done;
      end
    end
  end

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input bit ren, input bit spam);
    item_t it;
    it.tx = tx; it.rx = slv; it.ren = ren; it.old = rdata;
    q.push_back(it);
    @(negedge clk);
    slv_byte = slv; sdi = slv[0]; rx_en = ren;
    wr = 1'b1; wdata = tx; wr_cyc = cyc;
    @(negedge clk); wr = 1'b0;
    if (spam) begin
      // R9: write while armed, then while sending
      wr = 1'b1; wdata = ~tx;
      @(negedge clk); wr = 1'b0;
      repeat (3 * n_eff()) @(negedge clk);
      wr = 1'b1; wdata = 8'h5A;
      @(negedge clk); wr = 1'b0;
    end
    wait (tx_done);
    repeat (12) @(negedge clk);
    chk(tx_done, "R6 tx_done sticky", tx_done, 1);
    if (ren) chk(rx_done, "R7 rx_done sticky", rx_done, 1);
    clr_tx = 1'b1; clr_rx = 1'b1;
    @(negedge clk); clr_tx = 1'b0; clr_rx = 1'b0;
    @(negedge clk);
    chk(!tx_done && !rx_done, "R6 R7 flags cleared", {tx_done, rx_done}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R6 watchdog: no completion act=0 exp=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk && sdo, "R1 lines high in reset", {sclk, sdo}, 3);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(sclk && sdo, "R1 idle lines", {sclk, sdo}, 3);
    chk(!tx_done && !rx_done, "R1 flags clear", {tx_done, rx_done}, 0);
    chk(rdata == 8'h00, "R1 rdata reset", rdata, 0);

    div = 8'd4;
    xfer(8'hA5, 8'h3C, 1'b1, 1'b0);
    xfer(8'h01, 8'h80, 1'b1, 1'b0);
    xfer(8'h80, 8'hFF, 1'b0, 1'b0);    // R8
    div = 8'd5;
    xfer(8'hFF, 8'h00, 1'b1, 1'b1);    // R9, odd slot
    div = 8'd1;
    xfer(8'h6E, 8'hB7, 1'b1, 1'b0);    // R11
    div = 8'd0;
    xfer(8'h00, 8'h55, 1'b1, 1'b0);    // R11

    // R10: disabled port ignores writes
    div = 8'd2;
    en = 1'b0;
    @(negedge clk); wr = 1'b1; wdata = 8'hC3; rx_en = 1'b1;
    @(negedge clk); wr = 1'b0;
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!sclk || !sdo || tx_done || rx_done) quiet = 1'b0;
      end
      chk(quiet, "R10 disabled port stays quiet", quiet, 1);
    end
    en = 1'b1;
    repeat (2 * n_eff() + 2) @(negedge clk);
    chk(sclk && !tx_done, "R10 dropped write not sent later", {sclk, tx_done}, 2);

    div = 8'd7;
    xfer(8'hC9, 8'h2D, 1'b1, 1'b0);
    div = 8'd2;
    xfer(8'h3E, 8'hD4, 1'b1, 1'b0);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9 scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule